// File: doc/BRIEF.md
# FM Sound Generator Host Register Interface

This block sits between a host byte bus and the tone engine of a six-channel, four-operator FM sound generator. The host sees four byte addresses. They form two banks. In each bank, one address latches a register number and the other writes a data byte to the latched register. The block decodes these data writes into per-channel pitch, octave and algorithm settings. It also decodes per-operator frequency multipliers, the two timer reload values, key-on commands and DAC control. All decoded settings are held on parallel output buses for the tone, timer and mixer logic.

Key-on commands and DAC samples are delivered as single-cycle strobes, with their payloads held alongside. A read at any of the four addresses returns a status byte built from the two timer overflow flags.

A channel's pitch is written as two bytes. The high byte, which also carries the octave, is staged per channel. It reaches the outputs only when the low byte for that channel is written. The tone engine therefore never sees a half-updated pitch.

Top module: `fmRegIf`

## Requirements
- R1: Address 0 latches a register number for bank 0 and address 1 writes data to it; address 2 latches the register number for bank 1 and address 3 writes data to it. Bank 1 channel registers address channels 3 to 5 (channel = slot + 3 × bank).
- R2: While a bank's latched register number is zero, a data write to that bank changes no output and raises no strobe.
- R3: Register 0x24 sets bits 9:2 of the 10-bit timer A reload, and bits 1:0 of a write to 0x25 set its bits 1:0; each write leaves the other part unchanged.
- R4: Register 0x26 sets the 8-bit timer B reload.
- R5: A write to 0x28 raises `keyOnStb` for exactly one cycle, the cycle after the write, with `keyOnCh` taken from data bits 2:0 and `keyOnMask` from data bits 7:4.
- R6: Data bit 7 of a 0x2B write sets the DAC enable; a write to 0x2A raises `dacStb` for one cycle with `dacData` equal to the written byte only while the DAC is enabled, and otherwise has no effect.
- R7: A write to 0xA4 to 0xA6 (slot = reg − 0xA4) stages frequency-number bits 10:8 from data bits 2:0 and the octave from data bits 5:3 for that channel, without changing any output.
- R8: A write to 0xA0 to 0xA2 (slot = reg − 0xA0) sets the channel's 11-bit frequency output to {staged bits, data} and its octave output to the staged octave; no other write changes these outputs.
- R9: A write to 0xB0 to 0xB2 sets the channel's algorithm output from data bits 2:0.
- R10: A write to 0x30 to 0x3F with reg bits 1:0 below 3 sets the 4-bit multiplier code of operator reg[3:2] of channel reg[1:0] + 3 × bank from data bits 3:0; code 0 stands for a multiplier of one half.
- R11: During a read, `busRdata` is {6'b0, timerAOvf, timerBOvf} at every address; it is zero while no read is active.
- R12: A data write to any other register number (including slot 3 of the channel ranges and 0x27) changes no output and raises `unhandledStb` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Port address: bit 1 bank, bit 0 data/latch |
| busWr | input | 1 | Write enable |
| busRd | input | 1 | Read enable |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Status byte |
| timerAOvf | input | 1 | Timer A overflow flag |
| timerBOvf | input | 1 | Timer B overflow flag |
| timerAReload | output | 10 | Timer A reload value |
| timerBReload | output | 8 | Timer B reload value |
| keyOnStb | output | 1 | Key-on command strobe |
| keyOnCh | output | 3 | Key-on channel code |
| keyOnMask | output | 4 | Key-on operator mask |
| dacEn | output | 1 | DAC enable |
| dacStb | output | 1 | DAC sample strobe |
| dacData | output | 8 | DAC sample |
| freqNum | output | 66 | Per-channel 11-bit frequency number, channel c at [11c+10:11c] |
| freqBlock | output | 18 | Per-channel octave, channel c at [3c+2:3c] |
| algo | output | 18 | Per-channel algorithm, channel c at [3c+2:3c] |
| mulCode | output | 96 | Per-operator multiplier code, operator o of channel c at [4(4c+o)+3:4(4c+o)] |
| unhandledStb | output | 1 | Unhandled write pulse |

## Verification
The bench builds the block with its default parameters: three channels per bank and four operators per channel. This places every decoded channel slot, both banks and the unused fourth slot within reach. With these values the bench can reach bank-1 channel mapping, staged pitch writes that stay invisible until the low byte arrives, and split timer-A writes. It can also reach DAC writes on either side of the enable and the zero-selection case.

// File: rtl/fmRegPkg.sv
package fmRegPkg;
  localparam int CH_W = 3;
  localparam int OP_W = 2;

  typedef struct packed {
    logic timerAHi;
    logic timerALo;
    logic timerB;
    logic keyOn;
    logic dacSample;
    logic dacCtl;
    logic freqHi;
    logic freqLo;
    logic algoWr;
    logic mulWr;
    logic unhandled;
    logic [CH_W-1:0] ch;
    logic [OP_W-1:0] op;
    logic [7:0] data;
  } wrCmd_t;
endpackage

// File: rtl/fmRegCtrl.sv
module fmRegCtrl
  import fmRegPkg::*;
#(
  parameter int CH_PER_BANK = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  output wrCmd_t     cmd
);
  localparam int NUM_BANK = 2;

  logic [7:0] selNum [NUM_BANK];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rstN) selNum[b] <= '0;
      else if (busWr && !busAddr[0] && busAddr[1] == b[0]) selNum[b] <= busWdata;
    end
  end

  logic       dataWr;
  logic [7:0] regNum;
  logic       slotOk;
  logic [CH_W-1:0] chIdx;

  assign dataWr = busWr && busAddr[0];
  assign regNum = selNum[busAddr[1]];
  assign slotOk = (32'(regNum[1:0]) < CH_PER_BANK);
  assign chIdx  = CH_W'(regNum[1:0]) + (busAddr[1] ? CH_W'(CH_PER_BANK) : '0);

  always_comb begin
    cmd      = '0;
    cmd.ch   = chIdx;
    cmd.op   = regNum[3:2];
    cmd.data = busWdata;
    if (dataWr && regNum != 8'h00) begin
      if (regNum == 8'h24)      cmd.timerAHi  = 1'b1;
      else if (regNum == 8'h25) cmd.timerALo  = 1'b1;
      else if (regNum == 8'h26) cmd.timerB    = 1'b1;
      else if (regNum == 8'h28) cmd.keyOn     = 1'b1;
      else if (regNum == 8'h2A) cmd.dacSample = 1'b1;
      else if (regNum == 8'h2B) cmd.dacCtl    = 1'b1;
      else if (regNum[7:4] == 4'h3 && slotOk) cmd.mulWr = 1'b1;
      else if (regNum[7:2] == 6'b1010_00 && slotOk) cmd.freqLo = 1'b1;
      else if (regNum[7:2] == 6'b1010_01 && slotOk) cmd.freqHi = 1'b1;
      else if (regNum[7:2] == 6'b1011_00 && slotOk) cmd.algoWr = 1'b1;
      else cmd.unhandled = 1'b1;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.timerAHi, cmd.timerALo, cmd.timerB, cmd.keyOn, cmd.dacSample,
              cmd.dacCtl, cmd.freqHi, cmd.freqLo, cmd.algoWr, cmd.mulWr, cmd.unhandled})); // R12

  AST_ZERO_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[0] && selNum[busAddr[1]] == 8'h00) |->
    !(cmd.timerAHi || cmd.timerALo || cmd.timerB || cmd.keyOn || cmd.dacSample ||
      cmd.dacCtl || cmd.freqHi || cmd.freqLo || cmd.algoWr || cmd.mulWr || cmd.unhandled)); // R2
endmodule

// File: rtl/fmRegDp.sv
module fmRegDp
  import fmRegPkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int NUM_OP = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wrCmd_t                  cmd,
  output logic [9:0]              timerAReload,
  output logic [7:0]              timerBReload,
  output logic                    keyOnStb,
  output logic [CH_W-1:0]         keyOnCh,
  output logic [3:0]              keyOnMask,
  output logic                    dacEn,
  output logic                    dacStb,
  output logic [7:0]              dacData,
  output logic [NUM_CH*11-1:0]    freqNum,
  output logic [NUM_CH*3-1:0]     freqBlock,
  output logic [NUM_CH*3-1:0]     algo,
  output logic [NUM_CH*NUM_OP*4-1:0] mulCode,
  output logic                    unhandledStb
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerAReload <= '0;
      timerBReload <= '0;
      keyOnStb     <= 1'b0;
      keyOnCh      <= '0;
      keyOnMask    <= '0;
      dacEn        <= 1'b0;
      dacStb       <= 1'b0;
      dacData      <= '0;
      unhandledStb <= 1'b0;
    end else begin
      keyOnStb     <= cmd.keyOn;
      dacStb       <= cmd.dacSample && dacEn;
      unhandledStb <= cmd.unhandled;
      if (cmd.timerAHi) timerAReload[9:2] <= cmd.data;
      if (cmd.timerALo) timerAReload[1:0] <= cmd.data[1:0];
      if (cmd.timerB)   timerBReload      <= cmd.data;
      if (cmd.keyOn) begin
        keyOnCh   <= cmd.data[2:0];
        keyOnMask <= cmd.data[7:4];
      end
      if (cmd.dacCtl) dacEn <= cmd.data[7];
      if (cmd.dacSample && dacEn) dacData <= cmd.data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0] stageHi;
    logic [2:0] stageBlk;
    logic       hit;
    assign hit = (32'(cmd.ch) == c);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageHi              <= '0;
        stageBlk             <= '0;
        freqNum[c*11 +: 11]  <= '0;
        freqBlock[c*3 +: 3]  <= '0;
        algo[c*3 +: 3]       <= '0;
      end else if (hit) begin
        if (cmd.freqHi) begin
          stageHi  <= cmd.data[2:0];
          stageBlk <= cmd.data[5:3];
        end
        if (cmd.freqLo) begin
          freqNum[c*11 +: 11] <= {stageHi, cmd.data};
          freqBlock[c*3 +: 3] <= stageBlk;
        end
        if (cmd.algoWr) algo[c*3 +: 3] <= cmd.data[2:0];
      end
    end

    for (genvar o = 0; o < NUM_OP; o++) begin : g_op
      always_ff @(posedge clk) begin
        if (!rstN) mulCode[(c*NUM_OP+o)*4 +: 4] <= '0;
        else if (hit && cmd.mulWr && 32'(cmd.op) == o)
          mulCode[(c*NUM_OP+o)*4 +: 4] <= cmd.data[3:0];
      end
    end
  end

  AST_DAC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    dacStb |-> $past(dacEn)); // R6

  AST_FREQ_ONLY_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmd.freqLo) |-> ($stable(freqNum) && $stable(freqBlock))); // R8

  AST_UNHANDLED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.unhandled) |-> ($stable(timerAReload) && $stable(timerBReload) &&
                             $stable(algo) && $stable(mulCode) && $stable(dacEn))); // R12
endmodule

// File: rtl/fmRegIf.sv
module fmRegIf
  import fmRegPkg::*;
#(
  parameter int CH_PER_BANK = 3,
  parameter int NUM_OP      = 4,
  localparam int NUM_CH     = 2 * CH_PER_BANK
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 busAddr,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [7:0]                 busWdata,
  output logic [7:0]                 busRdata,
  input  logic                       timerAOvf,
  input  logic                       timerBOvf,
  output logic [9:0]                 timerAReload,
  output logic [7:0]                 timerBReload,
  output logic                       keyOnStb,
  output logic [2:0]                 keyOnCh,
  output logic [3:0]                 keyOnMask,
  output logic                       dacEn,
  output logic                       dacStb,
  output logic [7:0]                 dacData,
  output logic [NUM_CH*11-1:0]       freqNum,
  output logic [NUM_CH*3-1:0]        freqBlock,
  output logic [NUM_CH*3-1:0]        algo,
  output logic [NUM_CH*NUM_OP*4-1:0] mulCode,
  output logic                       unhandledStb
);
  wrCmd_t cmd;

  fmRegCtrl #(.CH_PER_BANK(CH_PER_BANK)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .cmd(cmd)
  );

  fmRegDp #(.NUM_CH(NUM_CH), .NUM_OP(NUM_OP)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .timerAReload(timerAReload), .timerBReload(timerBReload),
    .keyOnStb(keyOnStb), .keyOnCh(keyOnCh), .keyOnMask(keyOnMask),
    .dacEn(dacEn), .dacStb(dacStb), .dacData(dacData),
    .freqNum(freqNum), .freqBlock(freqBlock), .algo(algo),
    .mulCode(mulCode), .unhandledStb(unhandledStb)
  );

  assign busRdata = busRd ? {6'b0, timerAOvf, timerBOvf} : 8'h00;

  AST_KEYON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    keyOnStb |-> $past(busWr && busAddr[0])); // R5
endmodule

// File: tb/test_fmRegIf.sv
module test_fmRegIf;
  logic clk = 0;
  logic rstN = 0;
  logic [1:0] busAddr = '0;
  logic busWr = 0, busRd = 0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic timerAOvf = 0, timerBOvf = 0;
  logic [9:0] timerAReload;
  logic [7:0] timerBReload;
  logic keyOnStb;
  logic [2:0] keyOnCh;
  logic [3:0] keyOnMask;
  logic dacEn, dacStb;
  logic [7:0] dacData;
  logic [65:0] freqNum;
  logic [17:0] freqBlock, algo;
  logic [95:0] mulCode;
  logic unhandledStb;

  always #2.5 clk = ~clk;

  fmRegIf i_fmRegIf (.*);

  typedef enum int {S_TA, S_TB, S_KSTB, S_KCH, S_KMASK, S_DEN, S_DSTB, S_DDATA,
                    S_FREQ, S_BLK, S_ALGO, S_MUL, S_UNH, S_RD} sel_e;
  typedef struct { string req; sel_e sel; int idx; logic [31:0] val; } exp_t;
  exp_t q[$];
  event sampleEv;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  function automatic logic [31:0] getVal(sel_e s, int idx);
    case (s)
      S_TA:    return 32'(timerAReload);
      S_TB:    return 32'(timerBReload);
      S_KSTB:  return 32'(keyOnStb);
      S_KCH:   return 32'(keyOnCh);
      S_KMASK: return 32'(keyOnMask);
      S_DEN:   return 32'(dacEn);
      S_DSTB:  return 32'(dacStb);
      S_DDATA: return 32'(dacData);
      S_FREQ:  return 32'(freqNum[idx*11 +: 11]);
      S_BLK:   return 32'(freqBlock[idx*3 +: 3]);
      S_ALGO:  return 32'(algo[idx*3 +: 3]);
      S_MUL:   return 32'(mulCode[idx*4 +: 4]);
      S_UNH:   return 32'(unhandledStb);
      default: return 32'(busRdata);
    endcase
  endfunction

  // monitor: pops expected items when the driver marks a sample point
  always @(sampleEv) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      act = getVal(e.sel, e.idx);
      nChecks++;
      if (act !== e.val) begin
        nFail++;
        $display("FAIL %s sel=%s idx=%0d actual=%h expected=%h", e.req, e.sel.name(), e.idx, act, e.val);
      end
    end
  end

  task automatic expect_(string req, sel_e s, int idx, logic [31:0] v);
    exp_t e;
    e.req = req; e.sel = s; e.idx = idx; e.val = v;
    q.push_back(e);
  endtask

  task automatic sample();
    ->sampleEv;
    #0.1;
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic writeReg(int bank, logic [7:0] r, logic [7:0] d);
    busWrite(2'(bank * 2), r);
    busWrite(2'(bank * 2 + 1), d);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    expect_("R1", S_TA, 0, 0); expect_("R4", S_TB, 0, 0);
    expect_("R5", S_KSTB, 0, 0); expect_("R6", S_DEN, 0, 0);
    expect_("R8", S_FREQ, 3, 0); expect_("R10", S_MUL, 5, 0);
    sample();

    // R2: nothing selected on bank 0 (latch zero), data write ignored
    busWrite(2'd1, 8'h5A);
    expect_("R2", S_UNH, 0, 0); expect_("R2", S_TB, 0, 0); expect_("R2", S_TA, 0, 0);
    sample();

    // R4 timer B via bank 0
    writeReg(0, 8'h26, 8'hC3);
    expect_("R4", S_TB, 0, 32'hC3); sample();

    // R3 split timer A
    writeReg(0, 8'h24, 8'hAB);
    expect_("R3", S_TA, 0, 32'h2AC); sample();
    writeReg(0, 8'h25, 8'h02);
    expect_("R3", S_TA, 0, 32'h2AE); sample();
    writeReg(0, 8'h25, 8'hFF);
    expect_("R3", S_TA, 0, 32'h2AF); sample();
    writeReg(0, 8'h24, 8'h01);
    expect_("R3", S_TA, 0, 32'h007); sample();

    // R5 key-on pulse
    writeReg(0, 8'h28, 8'hA5);
    expect_("R5", S_KSTB, 0, 1); expect_("R5", S_KCH, 0, 5); expect_("R5", S_KMASK, 0, 4'hA);
    sample();
    @(negedge clk);
    expect_("R5", S_KSTB, 0, 0); expect_("R5", S_KMASK, 0, 4'hA); sample();

    // R6 DAC disabled: no strobe, data held
    writeReg(0, 8'h2A, 8'h33);
    expect_("R6", S_DSTB, 0, 0); expect_("R6", S_DDATA, 0, 0); sample();
    writeReg(0, 8'h2B, 8'h80);
    expect_("R6", S_DEN, 0, 1); sample();
    writeReg(0, 8'h2A, 8'h77);
    expect_("R6", S_DSTB, 0, 1); expect_("R6", S_DDATA, 0, 32'h77); sample();
    @(negedge clk);
    expect_("R6", S_DSTB, 0, 0); sample();
    writeReg(0, 8'h2B, 8'h7F);
    expect_("R6", S_DEN, 0, 0); sample();

    // R7/R8 staged pitch on channel 1
    writeReg(0, 8'hA5, 8'h2D);
    expect_("R7", S_FREQ, 1, 0); expect_("R7", S_BLK, 1, 0); sample();
    writeReg(0, 8'hA1, 8'h34);
    expect_("R8", S_FREQ, 1, 32'h534); expect_("R8", S_BLK, 1, 5);
    expect_("R8", S_FREQ, 0, 0); sample();

    // R1 bank 1 maps slot 0 to channel 3
    writeReg(1, 8'hA4, 8'h3F);
    writeReg(1, 8'hA0, 8'hFF);
    expect_("R1", S_FREQ, 3, 32'h7FF); expect_("R1", S_BLK, 3, 7);
    expect_("R1", S_FREQ, 0, 0); sample();

    // R9 algorithm, bank 1 slot 2 -> channel 5
    writeReg(1, 8'hB2, 8'hFE);
    expect_("R9", S_ALGO, 5, 6); expect_("R9", S_ALGO, 2, 0); sample();

    // R10 multiplier: reg 0x39 bank 1 -> op 2, channel 4
    writeReg(1, 8'h39, 8'hF7);
    expect_("R10", S_MUL, 4*4+2, 7); expect_("R10", S_MUL, 1*4+2, 0); sample();
    writeReg(1, 8'h39, 8'h00);
    expect_("R10", S_MUL, 4*4+2, 0); sample();

    // R12 unhandled numbers
    writeReg(0, 8'h50, 8'h11);
    expect_("R12", S_UNH, 0, 1); sample();
    @(negedge clk);
    expect_("R12", S_UNH, 0, 0); sample();
    writeReg(0, 8'h33, 8'h05);
    expect_("R12", S_UNH, 0, 1); expect_("R12", S_MUL, 0, 0); sample();
    writeReg(1, 8'hB3, 8'h07);
    expect_("R12", S_UNH, 0, 1); expect_("R12", S_ALGO, 3, 0); sample();

    // R2 again: bank 1 latched to zero
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'h44);
    expect_("R2", S_UNH, 0, 0); expect_("R2", S_ALGO, 5, 6); sample();

    // R11 status reads
    @(negedge clk);
    expect_("R11", S_RD, 0, 0); sample();
    for (int a = 0; a < 4; a++) begin
      busAddr = 2'(a); busRd = 1; timerAOvf = a[0]; timerBOvf = ~a[1];
      #0.5;
      expect_("R11", S_RD, 0, {30'b0, a[0], ~a[1]}); sample();
    end
    busRd = 0;

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule